// File: doc/BRIEF.md
# Two-Key Address Translation Unit

This block turns a logical block address inside one wear-levelled memory region into the physical slot that currently holds that block's data. The region is remapped one block at a time by a separate refresh engine. At any moment, each block is mapped either with the key of the previous round or with the key of the round in progress. The unit works out which key applies from just three values: the engine's refresh pointer and the two keys. It needs no per-block bookkeeping.

The selection uses the self-inverse nature of XOR. A block takes the new key if the pointer has already passed it. It also takes the new key if the block was evicted as the partner of an address the pointer has already passed. That partner address is the block address XOR both keys. The physical slot is the block address XOR the chosen key.

The datapath is combinational. A parameter adds one register stage on the outputs, so the unit can sit on a timing-critical path. The `sel_current` flag reports which key was used.

Top module: `remap_xlat_unit`

## Requirements
- R1: `out_slot` equals the presented `in_blk` XOR the selected key, where the selected key is `key_cur` when `out_sel_cur` is 1 and `key_prev` when it is 0.
- R2: When `in_blk` is below `refresh_ptr`, the current key is selected (`out_sel_cur` = 1).
- R3: When `in_blk` XOR `key_prev` XOR `key_cur` is below `refresh_ptr`, the current key is selected, even if `in_blk` itself is not below the pointer.
- R4: When neither R2 nor R3 holds, the previous key is selected (`out_sel_cur` = 0).
- R5: With `refresh_ptr` = 0, every address maps with `key_prev`; for example, with key 4, block 0 maps to slot 4.
- R6: Both comparisons are unsigned over the full `ADDR_W` bits. For example, block 0x80 is not below pointer 0x7F.
- R7: When `key_prev` equals `key_cur`, `out_slot` is `in_blk` XOR that key, whichever key is selected.
- R8: With `OUT_REG` = 1 (the default), all outputs show the result for inputs sampled one clock earlier, and `out_valid` follows `in_valid` by one clock. An active-low asynchronous reset drives `out_valid`, `out_sel_cur` and `out_slot` to 0.
- R9: For fixed pointer and keys, the mapping is a permutation: the 2^`ADDR_W` block addresses land on 2^`ADDR_W` distinct slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup request qualifier |
| in_blk | input | ADDR_W | Logical block address to translate |
| refresh_ptr | input | ADDR_W | Next block the refresh engine will visit |
| key_prev | input | ADDR_W | Key of the previous refresh round |
| key_cur | input | ADDR_W | Key of the round in progress |
| out_valid | output | 1 | Qualifier for the translated result |
| out_slot | output | ADDR_W | Physical slot holding the block |
| out_sel_cur | output | 1 | 1 when the current key was used |

## Verification
Assertions check, on every cycle, that the output slot differs from the registered input by exactly one of the two keys (R1). They also check the below-pointer rule (R2), the zero-pointer case (R5), the equal-key case (R7) and the one-cycle valid latency (R8).

Some behaviours can only be shown by the bench's scenarios. The partner-eviction rule (R3) and the default to the old key (R4) are directed cases. So is the unsigned boundary at the top bit (R6). The permutation property (R9) is a full sweep of every address, with a bitmap of the slots already hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic {
      KEY_PREV = 1'b0,
      KEY_CUR  = 1'b1
   } key_sel_e;

endpackage

// File: rtl/xlat_key_select.sv
module xlat_key_select
   import xlat_pkg::*;
#(
   parameter int ADDR_W = 8
)(
   input  logic [ADDR_W-1:0] blk,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] kp,
   input  logic [ADDR_W-1:0] kc,
   output key_sel_e          sel,
   output logic [ADDR_W-1:0] key
);

   logic [ADDR_W-1:0] partner;
   logic              passed_self;
   logic              passed_partner;

   // Partner whose refresh would have evicted this block.
   assign partner        = blk ^ kp ^ kc;
   assign passed_self    = (blk < ptr);
   assign passed_partner = (partner < ptr);

   assign sel = (passed_self || passed_partner) ? KEY_CUR : KEY_PREV;
   assign key = (sel == KEY_CUR) ? kc : kp;

endmodule

// File: rtl/xlat_xor_map.sv
module xlat_xor_map #(
   parameter int ADDR_W = 8
)(
   input  logic [ADDR_W-1:0] blk,
   input  logic [ADDR_W-1:0] key,
   output logic [ADDR_W-1:0] slot
);

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      assign slot[b] = blk[b] ^ key[b];
   end

endmodule

// File: rtl/xlat_out_reg.sv
module xlat_out_reg #(
   parameter int W = 10
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

endmodule

// File: rtl/remap_xlat_unit.sv
module remap_xlat_unit
   import xlat_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_blk,
   input  logic [ADDR_W-1:0] refresh_ptr,
   input  logic [ADDR_W-1:0] key_prev,
   input  logic [ADDR_W-1:0] key_cur,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_slot,
   output logic              out_sel_cur
);

   localparam int BUNDLE_W = ADDR_W + 2;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("remap_xlat_unit: ADDR_W must lie in 1..32");
   end

   key_sel_e          sel;
   logic [ADDR_W-1:0] key;
   logic [ADDR_W-1:0] slot;
   logic [BUNDLE_W-1:0] bundle_d;
   logic [BUNDLE_W-1:0] bundle_q;

   xlat_key_select #(.ADDR_W(ADDR_W)) u_sel (
      .blk (in_blk),
      .ptr (refresh_ptr),
      .kp  (key_prev),
      .kc  (key_cur),
      .sel (sel),
      .key (key)
   );

   xlat_xor_map #(.ADDR_W(ADDR_W)) u_map (
      .blk  (in_blk),
      .key  (key),
      .slot (slot)
   );

   assign bundle_d = {in_valid, (sel == KEY_CUR), slot};

   if (OUT_REG) begin : g_reg
      xlat_out_reg #(.W(BUNDLE_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (bundle_d),
         .q     (bundle_q)
      );

      logic armed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) armed <= 1'b0;
         else        armed <= 1'b1;
      end

      AST_SLOT_ONE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && out_valid) |->
            ((out_slot ^ $past(in_blk)) == $past(key_prev) ||
             (out_slot ^ $past(in_blk)) == $past(key_cur))); // R1
      AST_BELOW_PTR_CUR: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_blk < refresh_ptr)) |-> out_sel_cur); // R2
      AST_ZERO_PTR_PREV: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(refresh_ptr == '0)) |-> !out_sel_cur); // R5
      AST_EQUAL_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(key_prev == key_cur)) |->
            (out_slot == $past(in_blk ^ key_prev))); // R7
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> (out_valid == $past(in_valid))); // R8
   end else begin : g_comb
      assign bundle_q = bundle_d;
   end

   assign out_valid   = bundle_q[BUNDLE_W-1];
   assign out_sel_cur = bundle_q[BUNDLE_W-2];
   assign out_slot    = bundle_q[ADDR_W-1:0];

endmodule

// File: tb/remap_xlat_unit_tb.sv
module remap_xlat_unit_tb_top;

   localparam int AW = 8;
   localparam int NV = 12;

   // {blk, ptr, kp, kc, exp_slot, exp_sel(8b)}
   localparam logic [47:0] VEC [NV] = '{
      {8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h00},  // R5
      {8'h00, 8'h01, 8'h04, 8'h06, 8'h06, 8'h01},  // R2
      {8'h02, 8'h01, 8'h04, 8'h06, 8'h04, 8'h01},  // R3
      {8'h01, 8'h01, 8'h04, 8'h06, 8'h05, 8'h00},  // R4
      {8'h02, 8'h03, 8'h04, 8'h06, 8'h04, 8'h01},  // R2
      {8'h03, 8'h02, 8'h04, 8'h06, 8'h05, 8'h01},  // R3
      {8'h07, 8'h02, 8'h04, 8'h06, 8'h03, 8'h00},  // R4
      {8'h80, 8'h7F, 8'h10, 8'h20, 8'h90, 8'h00},  // R6
      {8'h7E, 8'h7F, 8'h10, 8'h20, 8'h5E, 8'h01},  // R6
      {8'h33, 8'h40, 8'hA5, 8'hA5, 8'h96, 8'h01},  // R7
      {8'h50, 8'h40, 8'hA5, 8'hA5, 8'hF5, 8'h00},  // R7
      {8'hFF, 8'hFF, 8'h00, 8'h01, 8'hFE, 8'h01}   // R3
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] in_blk = '0, refresh_ptr = '0, key_prev = '0, key_cur = '0;
   logic          out_valid;
   logic [AW-1:0] out_slot;
   logic          out_sel_cur;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   remap_xlat_unit #(.ADDR_W(AW), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blk(in_blk),
      .refresh_ptr(refresh_ptr), .key_prev(key_prev), .key_cur(key_cur),
      .out_valid(out_valid), .out_slot(out_slot), .out_sel_cur(out_sel_cur)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply(logic v, logic [AW-1:0] b, logic [AW-1:0] p,
                        logic [AW-1:0] kp, logic [AW-1:0] kc);
      @(negedge clk);
      in_valid = v; in_blk = b; refresh_ptr = p; key_prev = kp; key_cur = kc;
      @(negedge clk);
   endtask

   // Reference selection straight from the requirements (R2, R3, R4).
   function automatic logic ref_sel(logic [AW-1:0] b, logic [AW-1:0] p,
                                    logic [AW-1:0] kp, logic [AW-1:0] kc);
      return (b < p) || ((b ^ kp ^ kc) < p);
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state (R8)
      repeat (3) @(negedge clk);
      check("R8 reset valid", out_valid, 0);
      check("R8 reset slot", out_slot, 0);
      check("R8 reset sel", out_sel_cur, 0);
      rst_n = 1'b1;

      // Vector table (R1..R7)
      for (int i = 0; i < NV; i++) begin
         apply(1'b1, VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
         check($sformatf("R1 vec%0d slot", i), out_slot, VEC[i][15:8]);
         check($sformatf("R2/R3/R4 vec%0d sel", i), out_sel_cur, VEC[i][0]);
      end

      // Valid latency (R8)
      apply(1'b0, 8'h11, 8'h22, 8'h33, 8'h44);
      check("R8 valid low", out_valid, 0);
      @(negedge clk);
      in_valid = 1'b1;
      check("R8 valid not early", out_valid, 0);
      @(negedge clk);
      check("R8 valid one cycle later", out_valid, 1);

      // Permutation sweep (R9, also R1 by reference model)
      begin
         logic [255:0] seen = '0;
         int dup = 0;
         for (int a = 0; a < 256; a++) begin
            logic s;
            s = ref_sel(AW'(a), 8'h5A, 8'h3C, 8'hC3);
            apply(1'b1, AW'(a), 8'h5A, 8'h3C, 8'hC3);
            check("R1 sweep slot", out_slot, AW'(a) ^ (s ? 8'hC3 : 8'h3C));
            if (seen[out_slot]) dup++;
            seen[out_slot] = 1'b1;
         end
         check("R9 distinct slots", dup, 0);
      end

      // Mid-reset clears outputs (R8)
      apply(1'b1, 8'h01, 8'h00, 8'hFF, 8'h00);
      rst_n = 1'b0;
      #1;
      check("R8 async reset slot", out_slot, 0);
      check("R8 async reset valid", out_valid, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule